// File: doc/BRIEF.md
# Line-Grouped Translation Cache with Shoot-Down

This block caches 32-bit page-table entries. A client looks them up by virtual page number (VPN). Storage is organised as lines, and each line covers four consecutive pages: VPNs that agree in all bits above bit 1 share one tag. A table walker installs entries through a fill port. When a page needs a line that is not held, a line is allocated. The line chosen is the one a round-robin pointer names, and the pointer advances on every such allocation.

Two invalidation operations exist. A full clear wipes one line per cycle and raises a clearing busy flag. A shoot-down register takes a VPN and a shoot command bit, then invalidates the one four-page line holding that VPN; its bit 31 reads back as a shooting busy flag. While either operation is in progress, the block blocks all other updates: lookups report a miss, and fills and new commands are dropped. Each lookup gives a one-cycle hit or miss pulse for statistics counters.

Top module: `tlb_line_cache`

## Requirements
- R1: A lookup of a VPN that was filled returns lookup_hit_o=1 and that page's entry on lookup_entry_o in the cycle after lookup_valid_i. Both outputs hold until the next lookup.
- R2: A lookup of a VPN that is not cached returns lookup_hit_o=0 and lookup_entry_o=0 in the cycle after the request.
- R3: Each lookup gives exactly one one-cycle pulse, on hit_pulse_o or miss_pulse_o, in the following cycle. Neither pulse appears in a cycle that follows no lookup.
- R4: A fill whose VPN[VPN_W-1:2] matches a line holding any valid page sets that page in that line and evicts nothing. Sixteen lines of four pages hold 64 pages at once.
- R5: A fill needing a new line replaces the line at the round-robin pointer. Once all lines are in use, the line allocated first is evicted by the next new line.
- R6: A write to the shoot-down register with bit 30 set invalidates all four pages of the line given by bits [VPN_W-1:2]. Bits [1:0] are ignored, and other lines are untouched.
- R7: After an accepted shoot write, bit 31 of shoot_rdata_o reads 1 for exactly two cycles and then 0. Bit 30 always reads 0. Bits [VPN_W-1:0] read the VPN last written.
- R8: A shoot write with bit 30 clear updates the stored VPN only. It invalidates nothing and raises no busy flag.
- R9: clear_req_i invalidates every entry. clear_busy_o is high for NUM_LINES+1 cycles, starting the cycle after the request.
- R10: While either busy flag is high, lookups return a miss, and fills, clear requests and shoot writes are ignored. An ignored shoot write also leaves the stored VPN unchanged.
- R11: If clear_req_i and a shoot write with bit 30 set arrive in the same idle cycle, the clear is taken and the shoot is dropped.
- R12: After reset, no entry is valid, and all outputs and the shoot-down readback are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vpn_i | input | VPN_W | Page number to look up |
| lookup_hit_o | output | 1 | Result of the last lookup: hit |
| lookup_entry_o | output | ENTRY_W | Entry of the last lookup, 0 on a miss |
| hit_pulse_o | output | 1 | One-cycle pulse for a hit |
| miss_pulse_o | output | 1 | One-cycle pulse for a miss |
| fill_valid_i | input | 1 | Install an entry |
| fill_vpn_i | input | VPN_W | Page number of the installed entry |
| fill_entry_i | input | ENTRY_W | Entry to install |
| clear_req_i | input | 1 | Request full invalidation |
| clear_busy_o | output | 1 | Full clear in progress |
| shoot_wr_i | input | 1 | Write strobe for the shoot-down register |
| shoot_wdata_i | input | 32 | Write data: bit 30 shoot, low bits VPN |
| shoot_rdata_o | output | 32 | Readback: bit 31 shooting busy, low bits stored VPN |

## Verification
Lookup results and pulses are registered, so they are due one cycle after the request. A shoot-down holds the busy bit for two cycles after the write. A clear holds its busy flag for NUM_LINES+1 cycles after the request. The bench drives inputs on the falling edge and samples on the falling edge after the edge that must produce each result. It counts busy cycles one falling edge at a time, so a flag that ends early or late is seen. A reference model of lines, valid bits and the round-robin pointer, kept in bench functions, gives the expected hit and entry for every random and directed lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned SLOT_W     = 2;
  localparam int unsigned LINE_PAGES = 1 << SLOT_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHOOT = 2'd1,
    ST_WIPE  = 2'd2,
    ST_DONE  = 2'd3
  } inv_state_e;

  typedef enum logic {
    KIND_SHOOT = 1'b0,
    KIND_WIPE  = 1'b1
  } inv_kind_e;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (advance_i) begin
      if (ptr_q == IDX_W'(NUM_LINES - 1)) ptr_q <= '0;
      else ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl import tlb_pkg::*; #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned TAG_W     = 18,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_req_i,
  input  logic             shoot_req_i,
  input  logic [TAG_W-1:0] shoot_tag_i,
  output logic             busy_o,
  output logic             clear_busy_o,
  output logic             shoot_busy_o,
  output logic             shoot_en_o,
  output logic [TAG_W-1:0] shoot_tag_o,
  output logic             wipe_en_o,
  output logic [IDX_W-1:0] wipe_idx_o
);
  inv_state_e       state_q;
  inv_kind_e        kind_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_SHOOT;
      tag_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // clear has priority over a simultaneous shoot
          if (clear_req_i) begin
            state_q <= ST_WIPE;
            kind_q  <= KIND_WIPE;
            idx_q   <= '0;
          end else if (shoot_req_i) begin
            state_q <= ST_SHOOT;
            kind_q  <= KIND_SHOOT;
            tag_q   <= shoot_tag_i;
          end
        end
        ST_SHOOT: state_q <= ST_DONE;
        ST_WIPE: begin
          if (idx_q == IDX_W'(NUM_LINES - 1)) state_q <= ST_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign clear_busy_o = busy_o && (kind_q == KIND_WIPE);
  assign shoot_busy_o = busy_o && (kind_q == KIND_SHOOT);
  assign shoot_en_o   = (state_q == ST_SHOOT);
  assign shoot_tag_o  = tag_q;
  assign wipe_en_o    = (state_q == ST_WIPE);
  assign wipe_idx_o   = idx_q;
endmodule

// File: rtl/tlb_line_store.sv
module tlb_line_store import tlb_pkg::*; #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned ENTRY_W   = 32,
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned TAG_W = VPN_W - SLOT_W,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VPN_W-1:0]   lu_vpn_i,
  output logic               lu_hit_o,
  output logic [ENTRY_W-1:0] lu_entry_o,
  input  logic               fill_en_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [ENTRY_W-1:0] fill_entry_i,
  input  logic [IDX_W-1:0]   victim_i,
  output logic               alloc_o,
  input  logic               shoot_en_i,
  input  logic [TAG_W-1:0]   shoot_tag_i,
  input  logic               wipe_en_i,
  input  logic [IDX_W-1:0]   wipe_idx_i
);
  logic [NUM_LINES-1:0][TAG_W-1:0]                   tag_all;
  logic [NUM_LINES-1:0][LINE_PAGES-1:0]              vld_all;
  logic [NUM_LINES-1:0][LINE_PAGES-1:0][ENTRY_W-1:0] dat_all;
  logic [NUM_LINES-1:0] lu_match, fill_match, shoot_match;
  logic                 fill_any;

  logic [TAG_W-1:0]  lu_tag, fill_tag;
  logic [SLOT_W-1:0] lu_slot, fill_slot;

  assign lu_tag    = lu_vpn_i[VPN_W-1:SLOT_W];
  assign lu_slot   = lu_vpn_i[SLOT_W-1:0];
  assign fill_tag  = fill_vpn_i[VPN_W-1:SLOT_W];
  assign fill_slot = fill_vpn_i[SLOT_W-1:0];

  assign fill_any = |fill_match;
  assign alloc_o  = fill_en_i && !fill_any;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [TAG_W-1:0]                   tag_q;
    logic [LINE_PAGES-1:0]              vld_q;
    logic [LINE_PAGES-1:0][ENTRY_W-1:0] dat_q;
    logic kill, wr_here;

    assign lu_match[g]    = (tag_q == lu_tag) && vld_q[lu_slot];
    assign fill_match[g]  = (|vld_q) && (tag_q == fill_tag);
    assign shoot_match[g] = (|vld_q) && (tag_q == shoot_tag_i);

    assign kill    = (wipe_en_i && (wipe_idx_i == IDX_W'(g))) || (shoot_en_i && shoot_match[g]);
    assign wr_here = fill_en_i && (fill_any ? fill_match[g] : (victim_i == IDX_W'(g)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        vld_q <= '0;
        dat_q <= '0;
      end else if (kill) begin
        vld_q <= '0;
      end else if (wr_here) begin
        if (!fill_any) begin
          tag_q <= fill_tag;
          vld_q <= LINE_PAGES'(1) << fill_slot;
        end else begin
          vld_q[fill_slot] <= 1'b1;
        end
        dat_q[fill_slot] <= fill_entry_i;
      end
    end

    assign tag_all[g] = tag_q;
    assign vld_all[g] = vld_q;
    assign dat_all[g] = dat_q;
  end

  always_comb begin
    lu_entry_o = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (lu_match[l]) lu_entry_o = lu_entry_o | dat_all[l][lu_slot];
    end
  end

  assign lu_hit_o = |lu_match;
endmodule

// File: rtl/tlb_line_cache.sv
module tlb_line_cache import tlb_pkg::*; #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned ENTRY_W   = 32,
  parameter int unsigned NUM_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [VPN_W-1:0]   lookup_vpn_i,
  output logic               lookup_hit_o,
  output logic [ENTRY_W-1:0] lookup_entry_o,
  output logic               hit_pulse_o,
  output logic               miss_pulse_o,
  input  logic               fill_valid_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [ENTRY_W-1:0] fill_entry_i,
  input  logic               clear_req_i,
  output logic               clear_busy_o,
  input  logic               shoot_wr_i,
  input  logic [31:0]        shoot_wdata_i,
  output logic [31:0]        shoot_rdata_o
);
  localparam int unsigned TAG_W   = VPN_W - SLOT_W;
  localparam int unsigned IDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned PAD_W   = 30 - VPN_W;
  localparam int unsigned SHOOT_B = 30;

  logic             busy, shoot_busy, shoot_en, wipe_en, alloc, fill_en;
  logic             shoot_cmd, st_hit;
  logic [TAG_W-1:0] shoot_tag;
  logic [IDX_W-1:0] wipe_idx, victim;
  logic [ENTRY_W-1:0] st_entry;
  logic [VPN_W-1:0] sd_vpn_q;
  logic             hit_q, hit_p_q, miss_p_q;
  logic [ENTRY_W-1:0] entry_q;
  logic             hit_now;

  assign shoot_cmd = shoot_wr_i && shoot_wdata_i[SHOOT_B] && !busy;
  assign fill_en   = fill_valid_i && !busy;
  assign hit_now   = st_hit && !busy;

  tlb_inval_ctrl #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_req_i  (clear_req_i),
    .shoot_req_i  (shoot_cmd),
    .shoot_tag_i  (shoot_wdata_i[VPN_W-1:SLOT_W]),
    .busy_o       (busy),
    .clear_busy_o (clear_busy_o),
    .shoot_busy_o (shoot_busy),
    .shoot_en_o   (shoot_en),
    .shoot_tag_o  (shoot_tag),
    .wipe_en_o    (wipe_en),
    .wipe_idx_o   (wipe_idx)
  );

  tlb_rr_ptr #(.NUM_LINES(NUM_LINES)) u_rr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (alloc),
    .ptr_o     (victim)
  );

  tlb_line_store #(.VPN_W(VPN_W), .ENTRY_W(ENTRY_W), .NUM_LINES(NUM_LINES)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lu_vpn_i     (lookup_vpn_i),
    .lu_hit_o     (st_hit),
    .lu_entry_o   (st_entry),
    .fill_en_i    (fill_en),
    .fill_vpn_i   (fill_vpn_i),
    .fill_entry_i (fill_entry_i),
    .victim_i     (victim),
    .alloc_o      (alloc),
    .shoot_en_i   (shoot_en),
    .shoot_tag_i  (shoot_tag),
    .wipe_en_i    (wipe_en),
    .wipe_idx_i   (wipe_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_vpn_q <= '0;
      hit_q    <= 1'b0;
      entry_q  <= '0;
      hit_p_q  <= 1'b0;
      miss_p_q <= 1'b0;
    end else begin
      if (shoot_wr_i && !busy) sd_vpn_q <= shoot_wdata_i[VPN_W-1:0];
      hit_p_q  <= lookup_valid_i && hit_now;
      miss_p_q <= lookup_valid_i && !hit_now;
      if (lookup_valid_i) begin
        hit_q   <= hit_now;
        entry_q <= hit_now ? st_entry : '0;
      end
    end
  end

  assign lookup_hit_o   = hit_q;
  assign lookup_entry_o = entry_q;
  assign hit_pulse_o    = hit_p_q;
  assign miss_pulse_o   = miss_p_q;
  assign shoot_rdata_o  = {shoot_busy, 1'b0, {PAD_W{1'b0}}, sd_vpn_q};
endmodule

// File: rtl/tlb_line_cache_chk.sv
module tlb_line_cache_chk #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned ENTRY_W   = 32,
  parameter int unsigned NUM_LINES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_valid_i,
  input logic               lookup_hit_o,
  input logic [ENTRY_W-1:0] lookup_entry_o,
  input logic               hit_pulse_o,
  input logic               miss_pulse_o,
  input logic               clear_req_i,
  input logic               clear_busy_o,
  input logic               shoot_wr_i,
  input logic [31:0]        shoot_wdata_i,
  input logic [31:0]        shoot_rdata_o
);
  localparam int unsigned CNT_W = $clog2(NUM_LINES + 2) + 1;
  logic [CNT_W-1:0] clr_cnt_q;
  logic             any_busy;

  assign any_busy = clear_busy_o || shoot_rdata_o[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_cnt_q <= '0;
    else if (clear_busy_o) clr_cnt_q <= clr_cnt_q + 1'b1;
    else clr_cnt_q <= '0;
  end

  // R3
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_pulse_o && miss_pulse_o));
  // R3
  pulse_after_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (hit_pulse_o || miss_pulse_o));
  // R3
  no_pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_pulse_o && !miss_pulse_o));
  // R2
  miss_zero_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_pulse_o |-> (!lookup_hit_o && lookup_entry_o == '0));
  // R10
  busy_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && any_busy) |=> (miss_pulse_o && !lookup_hit_o));
  // R7
  shoot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shoot_wr_i && shoot_wdata_i[30] && !clear_req_i && !any_busy) |=> shoot_rdata_o[31]);
  // R7
  shoot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shoot_rdata_o[31]) |=> shoot_rdata_o[31] ##1 !shoot_rdata_o[31]);
  // R9
  clear_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_req_i && !any_busy) |=> clear_busy_o);
  // R9
  clear_len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_busy_o |-> (clr_cnt_q <= CNT_W'(NUM_LINES)));
  // R9
  clear_len_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clear_busy_o) |-> (clr_cnt_q == CNT_W'(NUM_LINES + 1)));
  // R11
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_busy_o && shoot_rdata_o[31]));
endmodule

bind tlb_line_cache tlb_line_cache_chk #(
  .VPN_W(VPN_W), .ENTRY_W(ENTRY_W), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_hit_o   (lookup_hit_o),
  .lookup_entry_o (lookup_entry_o),
  .hit_pulse_o    (hit_pulse_o),
  .miss_pulse_o   (miss_pulse_o),
  .clear_req_i    (clear_req_i),
  .clear_busy_o   (clear_busy_o),
  .shoot_wr_i     (shoot_wr_i),
  .shoot_wdata_i  (shoot_wdata_i),
  .shoot_rdata_o  (shoot_rdata_o)
);

// File: tb/tlb_line_cache_tb.sv
module tlb_line_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int ENTRY_W = 32;
  localparam int NL = 16;
  localparam int TAG_W = VPN_W - 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lookup_valid_i = 1'b0;
  logic [VPN_W-1:0] lookup_vpn_i = '0;
  logic lookup_hit_o, hit_pulse_o, miss_pulse_o, clear_busy_o;
  logic [ENTRY_W-1:0] lookup_entry_o;
  logic fill_valid_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [ENTRY_W-1:0] fill_entry_i = '0;
  logic clear_req_i = 1'b0;
  logic shoot_wr_i = 1'b0;
  logic [31:0] shoot_wdata_i = '0;
  logic [31:0] shoot_rdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_line_cache #(.VPN_W(VPN_W), .ENTRY_W(ENTRY_W), .NUM_LINES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_vpn_i(lookup_vpn_i),
    .lookup_hit_o(lookup_hit_o), .lookup_entry_o(lookup_entry_o),
    .hit_pulse_o(hit_pulse_o), .miss_pulse_o(miss_pulse_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_entry_i(fill_entry_i),
    .clear_req_i(clear_req_i), .clear_busy_o(clear_busy_o),
    .shoot_wr_i(shoot_wr_i), .shoot_wdata_i(shoot_wdata_i), .shoot_rdata_o(shoot_rdata_o)
  );

  // reference model
  logic [TAG_W-1:0]   m_tag [NL];
  logic [3:0]         m_vld [NL];
  logic [ENTRY_W-1:0] m_dat [NL][4];
  int                 m_rr = 0;

  function automatic void m_reset();
    for (int l = 0; l < NL; l++) begin
      m_tag[l] = '0; m_vld[l] = '0;
      for (int s = 0; s < 4; s++) m_dat[l][s] = '0;
    end
    m_rr = 0;
  endfunction

  function automatic void m_fill(input logic [VPN_W-1:0] vpn, input logic [ENTRY_W-1:0] e);
    int hit_l = -1;
    for (int l = 0; l < NL; l++)
      if (m_vld[l] != 0 && m_tag[l] == vpn[VPN_W-1:2]) hit_l = l;
    if (hit_l >= 0) begin
      m_vld[hit_l][vpn[1:0]] = 1'b1;
      m_dat[hit_l][vpn[1:0]] = e;
    end else begin
      m_tag[m_rr] = vpn[VPN_W-1:2];
      m_vld[m_rr] = 4'b0001 << vpn[1:0];
      m_dat[m_rr][vpn[1:0]] = e;
      m_rr = (m_rr + 1) % NL;
    end
  endfunction

  function automatic bit m_look(input logic [VPN_W-1:0] vpn, output logic [ENTRY_W-1:0] e);
    e = '0;
    for (int l = 0; l < NL; l++)
      if (m_vld[l][vpn[1:0]] && m_tag[l] == vpn[VPN_W-1:2]) begin
        e = m_dat[l][vpn[1:0]];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic void m_shoot(input logic [TAG_W-1:0] t);
    for (int l = 0; l < NL; l++) if (m_tag[l] == t) m_vld[l] = '0;
  endfunction

  function automatic void m_clear();
    for (int l = 0; l < NL; l++) m_vld[l] = '0;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [ENTRY_W-1:0] e, input bit upd);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_entry_i = e;
    tick();
    fill_valid_i = 1'b0;
    if (upd) m_fill(vpn, e);
  endtask

  task automatic do_lookup(input logic [VPN_W-1:0] vpn, input bit exp_hit,
                           input logic [ENTRY_W-1:0] exp_e, input string req);
    lookup_valid_i = 1'b1; lookup_vpn_i = vpn;
    tick();
    lookup_valid_i = 1'b0;
    check(lookup_hit_o == exp_hit, req, 64'(lookup_hit_o), 64'(exp_hit));
    check(lookup_entry_o == exp_e, req, 64'(lookup_entry_o), 64'(exp_e));
    // R3 pulse matches result
    check(hit_pulse_o == exp_hit && miss_pulse_o == !exp_hit, "R3",
          64'({hit_pulse_o, miss_pulse_o}), 64'({exp_hit, !exp_hit}));
  endtask

  task automatic look_model(input logic [VPN_W-1:0] vpn, input string req);
    logic [ENTRY_W-1:0] e;
    bit h;
    h = m_look(vpn, e);
    do_lookup(vpn, h, e, req);
  endtask

  task automatic do_shoot(input logic [31:0] wd, input string req);
    shoot_wr_i = 1'b1; shoot_wdata_i = wd;
    tick();
    shoot_wr_i = 1'b0;
    if (wd[30]) begin
      check(shoot_rdata_o[31] == 1'b1, "R7", 64'(shoot_rdata_o[31]), 64'd1);
      check(shoot_rdata_o[30] == 1'b0, "R7", 64'(shoot_rdata_o[30]), 64'd0);
      tick();
      check(shoot_rdata_o[31] == 1'b1, "R7", 64'(shoot_rdata_o[31]), 64'd1);
      tick();
      check(shoot_rdata_o[31] == 1'b0, "R7", 64'(shoot_rdata_o[31]), 64'd0);
      m_shoot(wd[VPN_W-1:2]);
    end else begin
      check(shoot_rdata_o[31] == 1'b0, req, 64'(shoot_rdata_o[31]), 64'd0);
    end
    check(shoot_rdata_o[VPN_W-1:0] == wd[VPN_W-1:0], "R7",
          64'(shoot_rdata_o[VPN_W-1:0]), 64'(wd[VPN_W-1:0]));
  endtask

  task automatic wait_clear_len(input int already);
    int cnt = already;
    while (clear_busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == NL + 1, "R9", 64'(cnt), 64'(NL + 1));
  endtask

  task automatic do_clear();
    clear_req_i = 1'b1;
    tick();
    clear_req_i = 1'b0;
    wait_clear_len(0);
    m_clear();
  endtask

  function automatic logic [VPN_W-1:0] mk(input int t, input int s);
    return VPN_W'((t << 2) | (s & 3));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [VPN_W-1:0] first_vpn;
    logic [ENTRY_W-1:0] first_e;
    m_reset();
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(lookup_hit_o == 0 && lookup_entry_o == 0, "R12", 64'(lookup_entry_o), 64'd0);
    check(hit_pulse_o == 0 && miss_pulse_o == 0 && clear_busy_o == 0, "R12",
          64'({hit_pulse_o, miss_pulse_o, clear_busy_o}), 64'd0);
    check(shoot_rdata_o == 32'd0, "R12", 64'(shoot_rdata_o), 64'd0);
    do_lookup(mk(5, 1), 1'b0, '0, "R12");

    // R1, R2
    do_fill(mk(7, 2), 32'hA5A5_0001, 1'b1);
    do_lookup(mk(7, 2), 1'b1, 32'hA5A5_0001, "R1");
    tick();
    check(lookup_hit_o == 1'b1 && lookup_entry_o == 32'hA5A5_0001, "R1", 64'(lookup_entry_o), 64'hA5A5_0001);
    check(!hit_pulse_o && !miss_pulse_o, "R3", 64'({hit_pulse_o, miss_pulse_o}), 64'd0);
    do_lookup(mk(7, 3), 1'b0, '0, "R2");
    do_lookup(mk(8, 2), 1'b0, '0, "R2");

    // R4 full capacity: 16 lines x 4 pages
    do_clear();
    for (int t = 0; t < NL; t++)
      for (int s = 0; s < 4; s++) do_fill(mk(100 + t, s), 32'(32'h1000_0000 + t * 4 + s), 1'b1);
    for (int t = 0; t < NL; t++)
      for (int s = 0; s < 4; s++) do_lookup(mk(100 + t, s), 1'b1, 32'(32'h1000_0000 + t * 4 + s), "R4");

    // R5 round-robin eviction of the first line allocated
    do_clear();
    first_vpn = mk(200, 1);
    first_e = 32'h2000_0000;
    for (int t = 0; t < NL; t++) do_fill(mk(200 + t, 1), 32'(32'h2000_0000 + t), 1'b1);
    do_fill(mk(300, 0), 32'h3000_0000, 1'b1);
    do_lookup(first_vpn, 1'b0, '0, "R5");
    do_lookup(mk(201, 1), 1'b1, 32'h2000_0001, "R5");
    do_lookup(mk(300, 0), 1'b1, 32'h3000_0000, "R5");
    check(first_e != 0, "R5", 64'(first_e), 64'(first_e));

    // R6 shoot-down of one line, low bits ignored
    do_clear();
    for (int s = 0; s < 4; s++) begin
      do_fill(mk(40, s), 32'(32'h4000_0000 + s), 1'b1);
      do_fill(mk(41, s), 32'(32'h4100_0000 + s), 1'b1);
    end
    do_shoot(32'h4000_0000 | 32'(mk(40, 3)), "R6");
    for (int s = 0; s < 4; s++) do_lookup(mk(40, s), 1'b0, '0, "R6");
    for (int s = 0; s < 4; s++) do_lookup(mk(41, s), 1'b1, 32'(32'h4100_0000 + s), "R6");

    // R8 write without shoot bit
    do_shoot(32'(mk(41, 2)), "R8");
    do_lookup(mk(41, 2), 1'b1, 32'h4100_0002, "R8");

    // R10 activity during clear is ignored
    clear_req_i = 1'b1;
    tick();
    clear_req_i = 1'b0;
    do_lookup(mk(41, 1), 1'b0, '0, "R10");
    do_fill(mk(50, 0), 32'h5000_0000, 1'b0);
    shoot_wr_i = 1'b1; shoot_wdata_i = 32'h4000_0000 | 32'(mk(77, 0));
    tick();
    shoot_wr_i = 1'b0;
    clear_req_i = 1'b1;
    tick();
    clear_req_i = 1'b0;
    wait_clear_len(4);
    m_clear();
    check(shoot_rdata_o[VPN_W-1:0] == mk(41, 2) && !shoot_rdata_o[31], "R10",
          64'(shoot_rdata_o), 64'(mk(41, 2)));
    check(!clear_busy_o, "R10", 64'(clear_busy_o), 64'd0);
    do_lookup(mk(50, 0), 1'b0, '0, "R10");

    // R10 lookup during shoot busy
    do_fill(mk(60, 0), 32'h6000_0000, 1'b1);
    shoot_wr_i = 1'b1; shoot_wdata_i = 32'h4000_0000 | 32'(mk(61, 0));
    tick();
    shoot_wr_i = 1'b0;
    do_lookup(mk(60, 0), 1'b0, '0, "R10");
    tick();
    check(!shoot_rdata_o[31], "R7", 64'(shoot_rdata_o[31]), 64'd0);
    m_shoot(mk(61, 0) >> 2);
    do_lookup(mk(60, 0), 1'b1, 32'h6000_0000, "R10");

    // R11 simultaneous clear and shoot
    clear_req_i = 1'b1; shoot_wr_i = 1'b1; shoot_wdata_i = 32'h4000_0000 | 32'(mk(60, 0));
    tick();
    clear_req_i = 1'b0; shoot_wr_i = 1'b0;
    check(clear_busy_o == 1'b1, "R11", 64'(clear_busy_o), 64'd1);
    check(shoot_rdata_o[31] == 1'b0, "R11", 64'(shoot_rdata_o[31]), 64'd0);
    wait_clear_len(0);
    m_clear();
    do_lookup(mk(60, 0), 1'b0, '0, "R9");

    // random traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int op = int'($urandom_range(99, 0));
      logic [VPN_W-1:0] v = mk(int'($urandom_range(23, 0)) + 500, int'($urandom_range(3, 0)));
      if (op < 40) do_fill(v, $urandom(), 1'b1);
      else if (op < 90) look_model(v, "R1");
      else if (op < 98) do_shoot(32'h4000_0000 | 32'(v), "R6");
      else do_clear();
    end

    report();
  end
endmodule